// File: doc/BRIEF.md
# Set Replacement Policy Controller

This block keeps the replacement order of the ways in every set of a set-associative cache and names the way to replace when a line is allocated. Each way of a set carries a small age rank. Rank 0 is the head of the queue and marks the next victim. Rank NUM_WAYS-1 is the tail, the most-recently-used position. Only these rank fields change. No line data ever moves.

A run-time mode input selects one of three policies. LRU promotes a line on every hit. FIFO ignores hits. Random draws the victim from a free-running LFSR. On every allocation an invalid way is filled before any eviction is considered. An allocation flagged as non-temporal is placed at the head of the queue instead of the tail, so that it becomes the next victim and does not displace useful lines.

The cache presents a set index together with that set's valid bits. It then either reports a hit on one way or requests an allocation. The victim output is combinational, so the cache reads it in the same cycle as its allocation request. The rank update lands on the next clock edge.

Top module: `repl_policy_ctrl`

## Requirements
- R1: After reset, every set holds the identity order: way w has rank w, so way 0 is at the head and is the victim when all ways are valid.
- R2: `modeSel` encodes 2'b00 LRU, 2'b01 FIFO, 2'b10 random, and 2'b11 behaves as LRU. In LRU and FIFO mode with all ways valid, `victimWay` is the way whose rank is 0.
- R3: In every mode, if any way of the addressed set is invalid, `victimWay` is the lowest-numbered invalid way and `evictNeeded` is 0.
- R4: A normal allocation in LRU or FIFO mode moves the victim way to rank NUM_WAYS-1. Every way that had a higher rank moves one step toward the head, so the ranks remain a permutation of 0..NUM_WAYS-1.
- R5: A hit in LRU mode moves the hit way to rank NUM_WAYS-1, and the younger ways each move one step toward the head.
- R6: A hit in FIFO mode leaves the ranks of the set unchanged.
- R7: An allocation with `allocNonTemporal` set, in LRU or FIFO mode, places the victim way at rank 0. Every way that had a lower rank moves one step toward the tail.
- R8: In random mode with all ways valid, the victim comes from an LFSR that advances every cycle, reduced modulo NUM_WAYS. Hits and allocations in random mode leave the ranks unchanged.
- R9: A rank update takes effect on the clock edge after the request and touches only the addressed set. `victimWay` follows the current ranks and valid bits in the same cycle.
- R10: `evictNeeded` is 1 exactly when `allocReq` is high and every way of the set is valid. A hit and an allocation in the same cycle are not allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Replacement policy select |
| setIdx | input | SET_W | Set addressed this cycle |
| hitValid | input | 1 | A lookup hit in the addressed set |
| hitWay | input | WAY_W | Way that hit |
| allocReq | input | 1 | Allocate a line in the addressed set |
| allocNonTemporal | input | 1 | The allocation is non-temporal: insert it at the head |
| wayValid | input | NUM_WAYS | Valid bits of the addressed set |
| victimWay | output | WAY_W | Way to fill or replace |
| evictNeeded | output | 1 | The allocation displaces a valid line |

## Verification
Assertions check the following on every cycle:
- The addressed set's ranks always form a permutation.
- An allocation into a set that still has an invalid way picks an invalid way and reports no eviction.
- With all ways valid in an ordered mode, the victim is the rank-0 way.
- A moved way lands at the tail or at the head on the next edge.
- Hits and allocations never coincide.
- The LFSR never locks up at zero.

Only the bench's scenarios can show that the whole queue evolves correctly across long mixed sequences, when compared against an independent rank model. The same holds for the following behaviours:
- FIFO mode ignores hits.
- A set that is not addressed keeps its order.
- The random victim actually varies over time.

// File: rtl/repl_pkg.sv
package repl_pkg;

  typedef enum logic [1:0] {
    MODE_LRU     = 2'b00,
    MODE_FIFO    = 2'b01,
    MODE_RAND    = 2'b10,
    MODE_LRU_ALT = 2'b11
  } replMode_e;

  // strobes from control to the rank datapath
  typedef struct packed {
    logic moveEn;   // rewrite the ranks of one set this cycle
    logic toHead;   // 1: moved way goes to rank 0, 0: to the tail
  } moveStrobe_t;

endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [LFSR_W-1:0] lfsrQ
);

  logic feedback;
  assign feedback = ^(lfsrQ & TAPS);

  always_ff @(posedge clk) begin
    if (!rstN) lfsrQ <= LFSR_W'(1);
    else       lfsrQ <= {lfsrQ[LFSR_W-2:0], feedback};
  end

  // R8: the generator must never lock up at zero
  a_r8_lfsr_live: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

endmodule

// File: rtl/repl_rank_dp.sv
module repl_rank_dp
  import repl_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [SET_W-1:0]                 rdSet,
  input  moveStrobe_t                      mvStrobe,
  input  logic [SET_W-1:0]                 mvSet,
  input  logic [WAY_W-1:0]                 mvWay,
  output logic [NUM_WAYS-1:0][WAY_W-1:0]   rdRanks
);

  localparam logic [WAY_W-1:0] TAIL_RANK = WAY_W'(NUM_WAYS - 1);

  logic [NUM_WAYS-1:0][WAY_W-1:0] rankMem [NUM_SETS];
  logic [NUM_WAYS-1:0][WAY_W-1:0] mvRow;
  logic [NUM_WAYS-1:0][WAY_W-1:0] nextRow;
  logic [WAY_W-1:0]               oldRank;

  assign rdRanks = rankMem[rdSet];
  assign mvRow   = rankMem[mvSet];
  assign oldRank = mvRow[mvWay];

  // per-way next rank: moved way jumps, the ways it passes shift by one
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    always_comb begin
      nextRow[w] = mvRow[w];
      if (WAY_W'(w) == mvWay) begin
        nextRow[w] = mvStrobe.toHead ? '0 : TAIL_RANK;
      end else if (!mvStrobe.toHead && (mvRow[w] > oldRank)) begin
        nextRow[w] = mvRow[w] - 1'b1;
      end else if (mvStrobe.toHead && (mvRow[w] < oldRank)) begin
        nextRow[w] = mvRow[w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          rankMem[s][w] <= WAY_W'(w);
        end
      end
    end else if (mvStrobe.moveEn) begin
      rankMem[mvSet] <= nextRow;
    end
  end

  // rank coverage of the read set, used to check the permutation property
  logic [NUM_WAYS-1:0] seenMask;
  always_comb begin
    seenMask = '0;
    for (int w = 0; w < NUM_WAYS; w++) seenMask[rdRanks[w]] = 1'b1;
  end

  a_r4_rank_perm: assert property (@(posedge clk) disable iff (!rstN)
    &seenMask);

  a_r4_fill_at_tail: assert property (@(posedge clk) disable iff (!rstN)
    mvStrobe.moveEn && !mvStrobe.toHead |=>
      rankMem[$past(mvSet)][$past(mvWay)] == TAIL_RANK);

  a_r7_nt_at_head: assert property (@(posedge clk) disable iff (!rstN)
    mvStrobe.moveEn && mvStrobe.toHead |=>
      rankMem[$past(mvSet)][$past(mvWay)] == '0);

endmodule

// File: rtl/repl_ctrl.sv
module repl_ctrl
  import repl_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int LFSR_W = 8,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [1:0]                     modeSel,
  input  logic                           hitValid,
  input  logic [WAY_W-1:0]               hitWay,
  input  logic                           allocReq,
  input  logic                           allocNonTemporal,
  input  logic [NUM_WAYS-1:0]            wayValid,
  input  logic [NUM_WAYS-1:0][WAY_W-1:0] curRanks,
  input  logic [LFSR_W-1:0]              lfsrQ,
  output logic [WAY_W-1:0]               victimWay,
  output logic                           evictNeeded,
  output moveStrobe_t                    strobe,
  output logic [WAY_W-1:0]               moveWay
);

  replMode_e mode;
  assign mode = replMode_e'(modeSel);

  logic orderedMode;
  logic promoteOnHit;
  assign orderedMode  = (mode != MODE_RAND);
  assign promoteOnHit = (mode == MODE_LRU) || (mode == MODE_LRU_ALT);

  logic             allValid;
  logic [WAY_W-1:0] firstInvalid;
  logic [WAY_W-1:0] headWay;
  logic [WAY_W-1:0] randWay;

  assign allValid = &wayValid;
  assign randWay  = WAY_W'(lfsrQ % LFSR_W'(NUM_WAYS));

  // lowest-numbered invalid way: scan downward so the lowest index wins
  always_comb begin
    firstInvalid = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!wayValid[w]) firstInvalid = WAY_W'(w);
    end
  end

  // head of the queue: the way holding rank 0
  always_comb begin
    headWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (curRanks[w] == '0) headWay = WAY_W'(w);
    end
  end

  always_comb begin
    if (!allValid)        victimWay = firstInvalid;
    else if (orderedMode) victimWay = headWay;
    else                  victimWay = randWay;
  end

  assign evictNeeded = allocReq && allValid;

  always_comb begin
    strobe  = '0;
    moveWay = victimWay;
    if (allocReq && orderedMode) begin
      strobe.moveEn = 1'b1;
      strobe.toHead = allocNonTemporal;
      moveWay       = victimWay;
    end else if (hitValid && promoteOnHit) begin
      strobe.moveEn = 1'b1;
      strobe.toHead = 1'b0;
      moveWay       = hitWay;
    end
  end

  a_r10_no_hit_alloc_clash: assert property (@(posedge clk) disable iff (!rstN)
    !(hitValid && allocReq));

  a_r3_fill_invalid_first: assert property (@(posedge clk) disable iff (!rstN)
    allocReq && !allValid |-> !evictNeeded && !wayValid[victimWay]);

  a_r2_victim_is_head: assert property (@(posedge clk) disable iff (!rstN)
    orderedMode && allValid |-> curRanks[victimWay] == '0);

  a_r6_fifo_hit_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_FIFO) && hitValid && !allocReq |-> !strobe.moveEn);

  a_r8_rand_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RAND) |-> !strobe.moveEn);

endmodule

// File: rtl/repl_policy_ctrl.sv
module repl_policy_ctrl
  import repl_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  parameter int LFSR_W = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  input  logic [SET_W-1:0]    setIdx,
  input  logic                hitValid,
  input  logic [WAY_W-1:0]    hitWay,
  input  logic                allocReq,
  input  logic                allocNonTemporal,
  input  logic [NUM_WAYS-1:0] wayValid,
  output logic [WAY_W-1:0]    victimWay,
  output logic                evictNeeded
);

  logic [NUM_WAYS-1:0][WAY_W-1:0] curRanks;
  logic [LFSR_W-1:0]              lfsrQ;
  moveStrobe_t                    strobe;
  logic [WAY_W-1:0]               moveWay;

  repl_lfsr #(.LFSR_W(LFSR_W)) uLfsr (
    .clk   (clk),
    .rstN  (rstN),
    .lfsrQ (lfsrQ)
  );

  repl_ctrl #(.NUM_WAYS(NUM_WAYS), .LFSR_W(LFSR_W)) uCtrl (
    .clk              (clk),
    .rstN             (rstN),
    .modeSel          (modeSel),
    .hitValid         (hitValid),
    .hitWay           (hitWay),
    .allocReq         (allocReq),
    .allocNonTemporal (allocNonTemporal),
    .wayValid         (wayValid),
    .curRanks         (curRanks),
    .lfsrQ            (lfsrQ),
    .victimWay        (victimWay),
    .evictNeeded      (evictNeeded),
    .strobe           (strobe),
    .moveWay          (moveWay)
  );

  repl_rank_dp #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .rdSet    (setIdx),
    .mvStrobe (strobe),
    .mvSet    (setIdx),
    .mvWay    (moveWay),
    .rdRanks  (curRanks)
  );

endmodule

// File: tb/sim_repl_policy_ctrl.sv
module sim_repl_policy_ctrl;

  localparam int NS = 8;
  localparam int NW = 4;
  localparam int WW = 2;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    modeSel;
  logic [SW-1:0] setIdx;
  logic          hitValid;
  logic [WW-1:0] hitWay;
  logic          allocReq;
  logic          allocNonTemporal;
  logic [NW-1:0] wayValid;
  logic [WW-1:0] victimWay;
  logic          evictNeeded;

  always #5 clk = ~clk;

  repl_policy_ctrl #(.NUM_SETS(NS), .NUM_WAYS(NW)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .setIdx(setIdx),
    .hitValid(hitValid), .hitWay(hitWay), .allocReq(allocReq),
    .allocNonTemporal(allocNonTemporal), .wayValid(wayValid),
    .victimWay(victimWay), .evictNeeded(evictNeeded)
  );

  int nChecks = 0;
  int nFails  = 0;
  int mRank [NS][NW];
  bit mValid[NS][NW];
  bit finished = 0;

  task automatic checkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  function automatic int headOf(int s);
    for (int w = 0; w < NW; w++) if (mRank[s][w] == 0) return w;
    return 0;
  endfunction

  function automatic int lowestInvalid(int s);
    for (int w = 0; w < NW; w++) if (!mValid[s][w]) return w;
    return -1;
  endfunction

  function automatic logic [NW-1:0] validVec(int s);
    logic [NW-1:0] v;
    for (int w = 0; w < NW; w++) v[w] = mValid[s][w];
    return v;
  endfunction

  function automatic void moveModel(int s, int w, bit toHead);
    int r = mRank[s][w];
    for (int x = 0; x < NW; x++) begin
      if (x == w) continue;
      if (!toHead && mRank[s][x] > r) mRank[s][x]--;
      if (toHead && mRank[s][x] < r) mRank[s][x]++;
    end
    mRank[s][w] = toHead ? 0 : NW - 1;
  endfunction

  // one cycle of stimulus; entered and left at a falling edge
  task automatic doVec(int mode, int s, bit hit, int hw, bit alloc, bit nt);
    int li, vic;
    modeSel = 2'(mode); setIdx = SW'(s); hitValid = hit; hitWay = WW'(hw);
    allocReq = alloc; allocNonTemporal = nt; wayValid = validVec(s);
    #1;
    li = lowestInvalid(s);
    vic = victimWay;
    checkEq("R10 evictNeeded", evictNeeded, (alloc && li < 0) ? 1 : 0);
    if (li >= 0)        checkEq("R3 lowest invalid victim", vic, li);
    else if (mode != 2) checkEq("R2 head victim", vic, headOf(s));
    else                checkEq("R8 random victim in range", (vic < NW) ? 1 : 0, 1);
    @(posedge clk);
    if (mode != 2) begin
      if (alloc)                            moveModel(s, vic, nt);
      else if (hit && (mode == 0 || mode == 3)) moveModel(s, hw, 0);
    end
    if (alloc) mValid[s][vic] = 1;
    @(negedge clk);
    hitValid = 0; allocReq = 0; allocNonTemporal = 0;
  endtask

  task automatic peek(int mode, int s, logic [NW-1:0] v, output int vic, output int ev);
    modeSel = 2'(mode); setIdx = SW'(s); wayValid = v;
    hitValid = 0; allocReq = 0; allocNonTemporal = 0;
    #1;
    vic = victimWay; ev = evictNeeded;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int vic, ev, distinct;
    bit [NW-1:0] seen;
    process::self().srandom(32'd1234);
    rstN = 0; modeSel = 0; setIdx = 0; hitValid = 0; hitWay = 0;
    allocReq = 0; allocNonTemporal = 0; wayValid = '0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin mRank[s][w] = w; mValid[s][w] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: identity order in every set
    for (int s = 0; s < NS; s++) begin
      peek(0, s, '1, vic, ev);
      checkEq("R1 reset head is way 0", vic, 0);
    end
    for (int w = 0; w < NW; w++) begin mValid[0][w] = 1; mValid[1][w] = 1; end

    // R5 LRU hit on way 0 -> way 1 heads
    doVec(0, 0, 1, 0, 0, 0);
    peek(0, 0, '1, vic, ev); checkEq("R5 LRU hit promotes", vic, 1);
    // R4 normal fill of way 1 -> way 2 heads
    doVec(0, 0, 0, 0, 1, 0);
    peek(0, 0, '1, vic, ev); checkEq("R4 fill goes to tail", vic, 2);
    // R7 non-temporal fill of way 2 keeps it at head
    doVec(1, 0, 0, 0, 1, 1);
    peek(1, 0, '1, vic, ev); checkEq("R7 non-temporal stays at head", vic, 2);
    doVec(3, 0, 0, 0, 1, 0);
    peek(3, 0, '1, vic, ev); checkEq("R4 mode 3 acts as LRU fill", vic, 3);
    // R6 FIFO hit on the head way changes nothing
    doVec(1, 1, 1, 0, 0, 0);
    peek(1, 1, '1, vic, ev); checkEq("R6 FIFO hit ignored", vic, 0);
    // R3 invalid ways win in every mode
    peek(2, 1, 4'b0110, vic, ev); checkEq("R3 random mode picks invalid", vic, 0);
    peek(0, 1, 4'b1011, vic, ev); checkEq("R3 picks way 2", vic, 2);
    // R9 set 3 untouched by activity elsewhere
    peek(0, 3, '1, vic, ev); checkEq("R9 other set keeps order", vic, 0);
    // R9 same-cycle victim reflects old ranks, change appears after the edge
    modeSel = 0; setIdx = 0; wayValid = '1; hitValid = 1; hitWay = WW'(headOf(0));
    #1; checkEq("R9 update not before edge", victimWay, headOf(0));
    @(posedge clk); moveModel(0, headOf(0), 0);
    @(negedge clk); hitValid = 0;
    #1; checkEq("R9 update after edge", victimWay, headOf(0));
    @(negedge clk);

    // R8 random victims vary over time
    seen = '0;
    for (int i = 0; i < 16; i++) begin
      peek(2, 1, '1, vic, ev);
      seen[vic] = 1;
      @(negedge clk);
    end
    distinct = $countones(seen);
    checkEq("R8 random victim varies", (distinct >= 2) ? 1 : 0, 1);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int s = $urandom_range(NS - 1);
      int mode = $urandom_range(3);
      int kind = $urandom_range(2);
      int hw;
      if ($urandom_range(7) == 0) mValid[s][$urandom_range(NW - 1)] = 0;
      hw = $urandom_range(NW - 1);
      if (kind == 1 && mValid[s][hw]) doVec(mode, s, 1, hw, 0, 0);
      else if (kind == 2) doVec(mode, s, 0, 0, 1, $urandom_range(3) == 0);
      else doVec(mode, s, 0, 0, 0, 0);
    end

    finished = 1;
    summary();
  end

endmodule